// File: doc/BRIEF.md
# Three-Wire Tuner Word Serializer

This block programs an external tuner over three lines: a serial clock, a serial data line and a latch enable. The tuner shifts data on the serial clock and only adopts a word when the latch enable pulses. Words are up to 24 bits long and are loaded left-aligned, so a 21-bit word is shifted up by three places. The host writes the word length once, then writes the word one byte at a time, most significant byte first. The block shifts each byte out as soon as it is written. The host polls two status pins between bytes. After the final byte the host raises and then drops a trigger bit, and the block pulses the latch enable.

A second path runs a whole tuning operation without the host stepping through it. A request carries four words and is taken with a valid/ready handshake. The block sends word 0, word 1, word 2 and word 3 in that order. Each word goes out as its bytes followed by a latch pulse. A one-cycle pulse on the done pin marks the end. The serial clock rate is set by a divider parameter: each half of a serial clock period lasts `CLK_DIV` system clocks.

Back-pressure rules:
- `seq_ready` is high only when the sequencer is idle and the shift engine is not busy.
- A request is taken on the rising clock edge where `seq_valid` and `seq_ready` are both high. The four words are captured on that edge.
- Before that edge, the words must be held stable while `seq_valid` is high.
- `seq_ready` stays low until the request has finished.

Top module: `tuner_word_serializer`

## Requirements
- R1: After reset, all of these are low: `tnr_clk`, `tnr_data`, `tnr_le`, `stat_busy`, `stat_byte_done` and `seq_done`. `seq_ready` is high. The word-length register resets to 24.
- R2: Host register map, selected by `host_addr`:
  - Address 0 is the word length, in bits 4:0. The values 1 to 24 are used as written. The values 0 and 25 to 31 mean 24.
  - Address 1 is the data byte.
  - Address 2 is the control register. Bit 1 is the trigger.
  - Address 3 does nothing.
- R3: Each byte is sent most significant bit first, starting in the cycle after the write. For each bit, `tnr_clk` is low for `CLK_DIV` cycles and then high for `CLK_DIV` cycles. `tnr_data` changes only while `tnr_clk` is low, so it is steady at every rising edge of `tnr_clk`.
- R4: Byte k of a word (k = 0, 1, 2) sends min(8, L - 8k) bits, where L is the effective word length. With L = 21 the bytes send 8, 8 and 5 bits. The three padding bits at the bottom of the last byte are never shifted out.
- R5: `stat_byte_done` rises when a byte that is not the last byte of the word finishes shifting. It is cleared when the next byte starts. It stays low after the last byte of a word.
- R6: `stat_busy` is high from the cycle after an accepted data-byte write until the last bit of that byte has finished its high phase.
- R7: A control write with bit 1 = 0, made while the stored trigger bit is 1 and the engine is idle, starts a latch pulse. During the pulse `tnr_le` is high for 2*`CLK_DIV` cycles, `tnr_clk` and `tnr_data` are low, and `stat_busy` is high.
- R8: A host write of any kind made while `stat_busy` is high has no effect. It does not shift a byte, move the byte position, change the length or change the trigger bit.
- R9: An accepted request sends its four words in index order, each right-aligned in `seq_words` (word i in bits 24i+23:24i). Each word goes out as its bytes and then a latch pulse.
  - There is one idle cycle after each byte.
  - There are two idle cycles between the end of one latch pulse and the next word.
  - There is one idle cycle between acceptance and the first byte.
- R10: `seq_done` is high for exactly one cycle: the second cycle after the last latch pulse of a request ends. `seq_ready` rises in that same cycle.
- R11: Host writes made while a request is in progress have no effect.
- R12: A write to the word-length register resets the byte position, so the next data byte is taken as byte 0 of a new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register address |
| host_wdata | input | 8 | Host write data |
| seq_valid | input | 1 | Tuning request valid |
| seq_words | input | NWORDS*8*BYTES | Four right-aligned words; word 0 in the low bits |
| seq_ready | output | 1 | Request can be accepted |
| seq_done | output | 1 | One-cycle pulse at the end of a request |
| stat_byte_done | output | 1 | A non-final byte has finished shifting |
| stat_busy | output | 1 | Engine shifting or pulsing the latch |
| tnr_clk | output | 1 | Serial clock to the tuner |
| tnr_data | output | 1 | Serial data to the tuner |
| tnr_le | output | 1 | Latch enable to the tuner |

## Verification
A byte-position counter that skips or fails to reset changes the bit count of the third byte. That shows up on `tnr_clk` within one serial bit period of the byte's expected end. It also gives a captured word of the wrong length at the next latch pulse. A divider or phase error moves a `tnr_clk` edge and is seen in the first bit of any byte. A trigger-state or sequencer-state error shows as a missing, extra or shifted `tnr_le` pulse, a misplaced `seq_done`, or a word arriving out of order. The bench compares every output pin against its model on every cycle, so any of these faults appears in the cycle where it first differs.

// File: rtl/tws_pkg.sv
package tws_pkg;

  typedef enum logic [1:0] {ENG_IDLE, ENG_LOW, ENG_HIGH, ENG_LATCH} eng_state_t;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_SEND, SEQ_LATCH, SEQ_WAIT} seq_state_t;

  localparam logic [1:0] ADDR_LEN  = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam int         TRIG_BIT  = 1;

  // zero or out-of-range lengths fall back to the full buffer width
  function automatic int eff_len(input int len, input int wmax);
    return (len == 0 || len > wmax) ? wmax : len;
  endfunction

  function automatic int bits_left(input int len, input int idx, input int wmax);
    return eff_len(len, wmax) - 8 * idx;
  endfunction

  function automatic logic [3:0] byte_bits(input int len, input int idx, input int wmax);
    int r;
    r = bits_left(len, idx, wmax);
    return (r > 8) ? 4'd8 : 4'(r);
  endfunction

  function automatic logic is_last(input int len, input int idx, input int wmax);
    return bits_left(len, idx, wmax) <= 8;
  endfunction

endpackage

// File: rtl/tws_engine.sv
module tws_engine
  import tws_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_shift,
  input  logic       start_latch,
  input  logic [7:0] byte_in,
  input  logic [3:0] nbits_in,
  input  logic       final_in,
  output logic       sclk,
  output logic       sdata,
  output logic       le,
  output logic       busy,
  output logic       byte_done
);

  localparam int CW = $clog2(2 * CLK_DIV);
  localparam logic [CW-1:0] HALF_END  = CW'(CLK_DIV - 1);
  localparam logic [CW-1:0] LATCH_END = CW'(2 * CLK_DIV - 1);

  eng_state_t     state;
  logic [CW-1:0]  cnt;
  logic [3:0]     bits;
  logic [7:0]     sreg;
  logic           final_q;

  assign sdata = sreg[7];
  assign busy  = (state != ENG_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ENG_IDLE;
      cnt       <= '0;
      bits      <= '0;
      sreg      <= '0;
      final_q   <= 1'b0;
      sclk      <= 1'b0;
      le        <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      case (state)
        ENG_IDLE: begin
          cnt <= '0;
          if (start_shift) begin
            sreg      <= byte_in;
            bits      <= nbits_in;
            final_q   <= final_in;
            byte_done <= 1'b0;
            state     <= ENG_LOW;
          end else if (start_latch) begin
            le    <= 1'b1;
            state <= ENG_LATCH;
          end
        end
        ENG_LOW: begin
          if (cnt == HALF_END) begin
            cnt   <= '0;
            sclk  <= 1'b1;
            state <= ENG_HIGH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ENG_HIGH: begin
          if (cnt == HALF_END) begin
            cnt  <= '0;
            sclk <= 1'b0;
            if (bits <= 4'd1) begin
              sreg      <= '0;
              byte_done <= !final_q;
              state     <= ENG_IDLE;
            end else begin
              sreg  <= {sreg[6:0], 1'b0};
              bits  <= bits - 1'b1;
              state <= ENG_LOW;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ENG_LATCH: begin
          if (cnt == LATCH_END) begin
            cnt   <= '0;
            le    <= 1'b0;
            state <= ENG_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  assert_data_steady_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdata));

  assert_le_clk_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(le && sclk));

  assert_le_data_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    le |-> (!sdata && busy));

endmodule

// File: rtl/tws_host_if.sv
module tws_host_if
  import tws_pkg::*;
#(
  parameter int BYTES = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [1:0]                      wr_addr,
  input  logic [7:0]                      wr_data,
  input  logic                            engine_busy,
  input  logic                            seq_active,
  output logic [$clog2(8*BYTES+1)-1:0]    len_q,
  output logic                            start_shift,
  output logic                            start_latch,
  output logic [7:0]                      byte_out,
  output logic [3:0]                      nbits,
  output logic                            final_out
);

  localparam int WMAX = 8 * BYTES;
  localparam int LW   = $clog2(WMAX + 1);
  localparam int IW   = (BYTES > 1) ? $clog2(BYTES) : 1;

  logic [IW-1:0] idx;
  logic          trig_q;
  logic          accept;

  assign accept      = wr_en && !engine_busy && !seq_active;
  assign byte_out    = wr_data;
  assign nbits       = byte_bits(int'(len_q), int'(idx), WMAX);
  assign final_out   = is_last(int'(len_q), int'(idx), WMAX);
  assign start_shift = accept && (wr_addr == ADDR_DATA);
  assign start_latch = accept && (wr_addr == ADDR_CTRL) && trig_q && !wr_data[TRIG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= LW'(WMAX);
      idx    <= '0;
      trig_q <= 1'b0;
    end else if (accept) begin
      case (wr_addr)
        ADDR_LEN: begin
          len_q <= wr_data[LW-1:0];
          idx   <= '0;
        end
        ADDR_DATA: idx <= final_out ? '0 : idx + 1'b1;
        ADDR_CTRL: trig_q <= wr_data[TRIG_BIT];
        default: ;
      endcase
    end
  end

  assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && engine_busy) |=> ($stable(idx) && $stable(len_q) && $stable(trig_q)));

  assert_seq_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && seq_active) |=> ($stable(idx) && $stable(len_q) && $stable(trig_q)));

  assert_len_resets_pos_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wr_addr == ADDR_LEN) |=> (idx == '0));

endmodule

// File: rtl/tws_seq.sv
module tws_seq
  import tws_pkg::*;
#(
  parameter int BYTES  = 3,
  parameter int NWORDS = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            seq_valid,
  input  logic [NWORDS*8*BYTES-1:0]       seq_words,
  input  logic [$clog2(8*BYTES+1)-1:0]    len_q,
  input  logic                            engine_busy,
  output logic                            seq_ready,
  output logic                            seq_done,
  output logic                            active,
  output logic                            start_shift,
  output logic                            start_latch,
  output logic [7:0]                      byte_out,
  output logic [3:0]                      nbits,
  output logic                            final_out
);

  localparam int WMAX = 8 * BYTES;
  localparam int IW   = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam int WIW  = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [WIW-1:0] LAST_WORD = WIW'(NWORDS - 1);

  seq_state_t                  state;
  logic [NWORDS*WMAX-1:0]      words_q;
  logic [WIW-1:0]              widx;
  logic [IW-1:0]               bidx;
  logic [WMAX-1:0]             cur_word;
  logic [WMAX-1:0]             aligned;

  always_comb begin
    cur_word = words_q[int'(widx)*WMAX +: WMAX];
    aligned  = cur_word << (WMAX - eff_len(int'(len_q), WMAX));
    byte_out = aligned[(WMAX-1) - 8*int'(bidx) -: 8];
  end

  assign nbits       = byte_bits(int'(len_q), int'(bidx), WMAX);
  assign final_out   = is_last(int'(len_q), int'(bidx), WMAX);
  assign active      = (state != SEQ_IDLE);
  assign seq_ready   = (state == SEQ_IDLE) && !engine_busy;
  assign start_shift = (state == SEQ_SEND) && !engine_busy;
  assign start_latch = (state == SEQ_LATCH) && !engine_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      words_q  <= '0;
      widx     <= '0;
      bidx     <= '0;
      seq_done <= 1'b0;
    end else begin
      seq_done <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (seq_valid && seq_ready) begin
            words_q <= seq_words;
            widx    <= '0;
            bidx    <= '0;
            state   <= SEQ_SEND;
          end
        end
        SEQ_SEND: begin
          if (!engine_busy) begin
            if (final_out) begin
              bidx  <= '0;
              state <= SEQ_LATCH;
            end else begin
              bidx <= bidx + 1'b1;
            end
          end
        end
        SEQ_LATCH: if (!engine_busy) state <= SEQ_WAIT;
        SEQ_WAIT: begin
          if (!engine_busy) begin
            if (widx == LAST_WORD) begin
              seq_done <= 1'b1;
              state    <= SEQ_IDLE;
            end else begin
              widx  <= widx + 1'b1;
              state <= SEQ_SEND;
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assert_words_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(words_q));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  assert_done_ends_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> (!active && $past(active)));

endmodule

// File: rtl/tuner_word_serializer.sv
module tuner_word_serializer
  import tws_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int BYTES   = 3,
  parameter int NWORDS  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        host_wr,
  input  logic [1:0]                  host_addr,
  input  logic [7:0]                  host_wdata,
  input  logic                        seq_valid,
  input  logic [NWORDS*8*BYTES-1:0]   seq_words,
  output logic                        seq_ready,
  output logic                        seq_done,
  output logic                        stat_byte_done,
  output logic                        stat_busy,
  output logic                        tnr_clk,
  output logic                        tnr_data,
  output logic                        tnr_le
);

  localparam int LW = $clog2(8 * BYTES + 1);

  logic [LW-1:0] len_q;
  logic          seq_active;
  logic          h_shift, h_latch, h_final;
  logic [7:0]    h_byte;
  logic [3:0]    h_nbits;
  logic          s_shift, s_latch, s_final;
  logic [7:0]    s_byte;
  logic [3:0]    s_nbits;
  logic          e_shift, e_latch, e_final;
  logic [7:0]    e_byte;
  logic [3:0]    e_nbits;

  tws_host_if #(.BYTES(BYTES)) u_host (
    .clk(clk), .rst_n(rst_n),
    .wr_en(host_wr), .wr_addr(host_addr), .wr_data(host_wdata),
    .engine_busy(stat_busy), .seq_active(seq_active),
    .len_q(len_q), .start_shift(h_shift), .start_latch(h_latch),
    .byte_out(h_byte), .nbits(h_nbits), .final_out(h_final)
  );

  tws_seq #(.BYTES(BYTES), .NWORDS(NWORDS)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .seq_valid(seq_valid), .seq_words(seq_words), .len_q(len_q),
    .engine_busy(stat_busy), .seq_ready(seq_ready), .seq_done(seq_done),
    .active(seq_active), .start_shift(s_shift), .start_latch(s_latch),
    .byte_out(s_byte), .nbits(s_nbits), .final_out(s_final)
  );

  always_comb begin
    if (seq_active) begin
      e_shift = s_shift; e_latch = s_latch; e_byte = s_byte;
      e_nbits = s_nbits; e_final = s_final;
    end else begin
      e_shift = h_shift; e_latch = h_latch; e_byte = h_byte;
      e_nbits = h_nbits; e_final = h_final;
    end
  end

  tws_engine #(.CLK_DIV(CLK_DIV)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .start_shift(e_shift), .start_latch(e_latch),
    .byte_in(e_byte), .nbits_in(e_nbits), .final_in(e_final),
    .sclk(tnr_clk), .sdata(tnr_data), .le(tnr_le),
    .busy(stat_busy), .byte_done(stat_byte_done)
  );

  assert_single_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({e_shift, e_latch}));

  assert_start_only_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (e_shift || e_latch) |-> !stat_busy);

  assert_shift_sets_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    e_shift |=> (stat_busy && !stat_byte_done));

endmodule

// File: tb/tuner_word_serializer_bench.sv
module tuner_word_serializer_bench;
  localparam int CLK_DIV = 4;
  localparam int BYTES   = 3;
  localparam int NWORDS  = 4;
  localparam int WMAX    = 8 * BYTES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic                      host_wr = 1'b0;
  logic [1:0]                host_addr = '0;
  logic [7:0]                host_wdata = '0;
  logic                      seq_valid = 1'b0;
  logic [NWORDS*WMAX-1:0]    seq_words = '0;
  logic seq_ready, seq_done, stat_byte_done, stat_busy, tnr_clk, tnr_data, tnr_le;

  tuner_word_serializer #(.CLK_DIV(CLK_DIV), .BYTES(BYTES), .NWORDS(NWORDS))
    u_tuner_word_serializer (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .seq_valid(seq_valid), .seq_words(seq_words),
    .seq_ready(seq_ready), .seq_done(seq_done), .stat_byte_done(stat_byte_done),
    .stat_busy(stat_busy), .tnr_clk(tnr_clk), .tnr_data(tnr_data), .tnr_le(tnr_le)
  );

  typedef struct packed {
    logic sclk; logic sdata; logic le; logic busy; logic bdone; logic ready; logic done;
  } samp_t;

  samp_t expq[$];
  samp_t dflt;
  samp_t cur;
  int checks = 0;
  int fails = 0;
  bit chk_en = 1'b0;
  bit finished = 1'b0;
  int m_len = 24;
  int m_idx = 0;
  bit m_trig = 1'b0;

  longint unsigned rx_val[$];
  int rx_cnt[$];
  longint unsigned acc = 0;
  int acc_n = 0;

  function automatic samp_t mk(input logic c, input logic d, input logic l, input logic b,
                               input logic bd, input logic r, input logic dn);
    samp_t s;
    s.sclk = c; s.sdata = d; s.le = l; s.busy = b; s.bdone = bd; s.ready = r; s.done = dn;
    return s;
  endfunction

  function automatic int eff(input int l);
    return (l == 0 || l > WMAX) ? WMAX : l;
  endfunction

  // tuner-side decoder: sample data on each rising serial clock, close a word on latch
  always @(posedge tnr_clk) begin
    acc = (acc << 1) | longint'(tnr_data);
    acc_n++;
  end
  always @(posedge tnr_le) begin
    rx_val.push_back(acc);
    rx_cnt.push_back(acc_n);
    acc = 0;
    acc_n = 0;
  end

  // per-cycle comparison against the behavioural model
  always @(negedge clk) begin
    samp_t e;
    samp_t a;
    string tag;
    if (chk_en && !finished) begin
      if (expq.size() > 0) e = expq.pop_front();
      else e = dflt;
      cur = e;
      a = mk(tnr_clk, tnr_data, tnr_le, stat_busy, stat_byte_done, seq_ready, seq_done);
      checks++;
      if (a !== e) begin
        fails++;
        if (a.sclk !== e.sclk || a.sdata !== e.sdata) tag = "R3";
        else if (a.le !== e.le) tag = "R7";
        else if (a.busy !== e.busy) tag = "R6";
        else if (a.bdone !== e.bdone) tag = "R5";
        else if (a.done !== e.done) tag = "R10";
        else tag = "R9";
        if (fails < 20)
          $display("FAIL %s pins{clk,data,le,busy,bdone,ready,done} at %0t actual %b expected %b",
                   tag, $time, a, e);
      end
    end
  end

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_byte(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      logic v;
      v = b[7-i];
      repeat (CLK_DIV) expq.push_back(mk(1'b0, v, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
      repeat (CLK_DIV) expq.push_back(mk(1'b1, v, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk);
    #1;
    if (cur.ready) begin
      case (a)
        2'd0: begin m_len = int'(d[4:0]); m_idx = 0; end
        2'd1: begin
          int n;
          bit fin;
          n = eff(m_len) - 8 * m_idx;
          fin = (n <= 8);
          if (n > 8) n = 8;
          push_byte(d, n);
          dflt.bdone = !fin;
          m_idx = fin ? 0 : m_idx + 1;
        end
        2'd2: begin
          if (m_trig && !d[1])
            repeat (2*CLK_DIV) expq.push_back(mk(1'b0, 1'b0, 1'b1, 1'b1, dflt.bdone, 1'b0, 1'b0));
          m_trig = d[1];
        end
        default: ;
      endcase
    end
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic seq_send(input logic [WMAX-1:0] w0, input logic [WMAX-1:0] w1,
                          input logic [WMAX-1:0] w2, input logic [WMAX-1:0] w3);
    logic [WMAX-1:0] ws [4];
    ws[0] = w0; ws[1] = w1; ws[2] = w2; ws[3] = w3;
    @(negedge clk);
    seq_valid = 1'b1;
    seq_words = {w3, w2, w1, w0};
    @(posedge clk);
    #1;
    if (cur.ready) begin
      expq.push_back(mk(1'b0, 1'b0, 1'b0, 1'b0, dflt.bdone, 1'b0, 1'b0));
      for (int w = 0; w < NWORDS; w++) begin
        logic [WMAX-1:0] al;
        al = ws[w] << (WMAX - eff(m_len));
        for (int k = 0; k < BYTES; k++) begin
          int n;
          bit fin;
          n = eff(m_len) - 8 * k;
          if (n > 0) begin
            fin = (n <= 8);
            if (n > 8) n = 8;
            push_byte(al[WMAX-1-8*k -: 8], n);
            expq.push_back(mk(1'b0, 1'b0, 1'b0, 1'b0, !fin, 1'b0, 1'b0));
          end
        end
        repeat (2*CLK_DIV) expq.push_back(mk(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0));
        if (w < NWORDS - 1) begin
          repeat (2) expq.push_back(mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        end else begin
          expq.push_back(mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
          expq.push_back(mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
        end
      end
      dflt = mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    end
    @(negedge clk);
    seq_valid = 1'b0;
  endtask

  task automatic wait_idle;
    while (expq.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_rx(input string req, input longint unsigned val, input int n);
    checks++;
    if (rx_val.size() == 0) begin
      fails++;
      $display("FAIL %s no latched word, expected %0h", req, val);
    end else begin
      longint unsigned v;
      int c;
      v = rx_val.pop_front();
      c = rx_cnt.pop_front();
      if (v !== val || c != n) begin
        fails++;
        $display("FAIL %s latched word actual %0h/%0d bits expected %0h/%0d bits", req, v, c, val, n);
      end
    end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1 watchdog expired actual running expected finished");
    finish_run();
  end

  initial begin
    logic [20:0] wa;
    logic [20:0] wb;
    logic [23:0] al;
    dflt = mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    cur = dflt;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 tnr_clk", tnr_clk, 0);
    check("R1 tnr_data", tnr_data, 0);
    check("R1 tnr_le", tnr_le, 0);
    check("R1 stat_busy", stat_busy, 0);
    check("R1 stat_byte_done", stat_byte_done, 0);
    check("R1 seq_ready", seq_ready, 1);
    check("R1 seq_done", seq_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_en = 1'b1;

    // R2 R3 R4 R5 R6 R7: one 21-bit word from the host
    host_write(2'd0, 8'd21);
    wa = 21'h15A3C7;
    al = {wa, 3'b000};
    host_write(2'd1, al[23:16]);
    wait_idle();
    check("R5 byte_done after byte 0", stat_byte_done, 1);
    host_write(2'd1, al[15:8]);
    wait_idle();
    host_write(2'd1, al[7:0]);
    wait_idle();
    check("R5 byte_done after last byte", stat_byte_done, 0);
    host_write(2'd2, 8'h02);
    host_write(2'd2, 8'h00);
    wait_idle();
    check_rx("R4 21-bit word", longint'(wa), 21);

    // R8 writes while busy are ignored
    wb = 21'h0F0F35;
    al = {wb, 3'b000};
    host_write(2'd2, 8'h02);
    host_write(2'd1, al[23:16]);
    host_write(2'd1, 8'hFF);
    host_write(2'd2, 8'h00);
    host_write(2'd0, 8'd5);
    wait_idle();
    check("R8 no latch from busy trigger", longint'(rx_val.size()), 0);
    host_write(2'd1, al[15:8]);
    wait_idle();
    host_write(2'd1, al[7:0]);
    wait_idle();
    host_write(2'd2, 8'h00);
    wait_idle();
    check_rx("R8 word after ignored writes", longint'(wb), 21);

    // R12 length write restarts the word; R4 16-bit word
    host_write(2'd1, 8'hAA);
    wait_idle();
    host_write(2'd0, 8'd16);
    host_write(2'd1, 8'h5C);
    wait_idle();
    check("R12 byte_done after restarted byte 0", stat_byte_done, 1);
    host_write(2'd1, 8'h93);
    wait_idle();
    check("R4 16-bit word ends at second byte", stat_byte_done, 0);
    host_write(2'd2, 8'h02);
    host_write(2'd2, 8'h00);
    wait_idle();
    check_rx("R12 stray byte then 16-bit word", 64'hAA5C93, 24);

    // R2 length 0 means 24, address 3 does nothing
    host_write(2'd0, 8'd0);
    host_write(2'd3, 8'hFF);
    host_write(2'd1, 8'hC3);
    wait_idle();
    host_write(2'd1, 8'h18);
    wait_idle();
    host_write(2'd1, 8'h7E);
    wait_idle();
    host_write(2'd2, 8'h02);
    host_write(2'd2, 8'h00);
    wait_idle();
    check_rx("R2 zero length means 24", 64'hC3187E, 24);

    // R9 R10 R11 sequencer with 21-bit words, host writes during the run
    host_write(2'd0, 8'd21);
    seq_send(24'h1C0E07, 24'h1300F0, 24'h000240, 24'h1A3F85);
    repeat (10) @(negedge clk);
    host_write(2'd1, 8'hFF);
    host_write(2'd2, 8'h02);
    host_write(2'd2, 8'h00);
    host_write(2'd0, 8'd8);
    wait_idle();
    check_rx("R9 word 0", 64'h1C0E07, 21);
    check_rx("R9 word 1", 64'h1300F0, 21);
    check_rx("R9 word 2", 64'h000240, 21);
    check_rx("R9 word 3", 64'h1A3F85, 21);
    check("R11 no extra latch from host", longint'(rx_val.size()), 0);
    check("R10 ready after run", seq_ready, 1);

    // R9 second run at 24 bits
    host_write(2'd0, 8'd24);
    seq_send(24'hFFFFFF, 24'h800001, 24'h123456, 24'h00FF00);
    wait_idle();
    check_rx("R9 24-bit word 0", 64'hFFFFFF, 24);
    check_rx("R9 24-bit word 1", 64'h800001, 24);
    check_rx("R9 24-bit word 2", 64'h123456, 24);
    check_rx("R9 24-bit word 3", 64'h00FF00, 24);

    finish_run();
  end

endmodule